// File: doc/BRIEF.md
# Integer-Ratio Clock Enable Generator

This block runs entirely on one fast clock. It produces a strobe that lets a bus interface advance at an integer fraction of that clock. It also produces a matching reference slow clock, so that the strobe-to-edge relationship can be observed. The strobe is high for one fast cycle in each slow period. The slow clock's rising edge follows each strobe by a fixed lead of `LEAD` fast cycles. A lead of 1 suits a logic block sitting next to the interface. A lead of 3 leaves room for propagation delay.

The divide ratio comes from an input and may be changed while the block runs. A request is taken only when the current slow period finishes, so every slow period is a whole period of either the old ratio or the new one. A request outside the legal range is not applied and the ratio in force is kept. Ratio 1 is outside that range whenever the lead is more than one cycle. At ratio 1 with a one-cycle lead, the strobe is high in every cycle and the reference clock sits high. An extra one-cycle marker, `edge_o`, shows where each slow rising edge falls, including at ratio 1.

Top module: `cken_gen`

## Requirements
- R1: While reset is high, and on the clock edge that applies it, `en_o`, `edge_o` and `slow_clk_o` are low. After reset the ratio in force is the default: 1 when `LEAD` is 1, otherwise 2.
- R2: `en_o` pulses for one fast cycle once per slow period. The distance between two consecutive pulses equals the ratio in force when the first of them was issued.
- R3: `edge_o` is high in exactly those cycles that come `LEAD` cycles after a cycle with `en_o` high. It is never high at any other time.
- R4: A request on `ratio_i` is sampled only on the last fast cycle of a slow period and applies from the next period. A period is never a mix of two ratios, and no period is shorter than the ratio it was issued with.
- R5: A request of 0, a request above `MAX_RATIO`, or a request of 1 with `LEAD` greater than 1 is ignored, and the ratio in force is kept.
- R6: At ratio 1 with `LEAD` = 1, `en_o` and `edge_o` are high every cycle and `slow_clk_o` stays high.
- R7: `slow_clk_o` rises together with `edge_o`. It stays high for the first ceil(N/2) cycles of each N-cycle slow period and is low for the rest.
- R8: The first `en_o` pulse after reset appears in the cycle after the first clock edge with reset low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_i | input | RATIO_W | Requested divide ratio N (slow period = N fast cycles) |
| en_o | output | 1 | Enable strobe, one cycle per slow period, `LEAD` cycles before the slow edge |
| edge_o | output | 1 | High in the first fast cycle of each slow-clock high phase |
| slow_clk_o | output | 1 | Reference divided clock |

## Verification
`en_o` changes one clock edge after the period counter reaches zero. `edge_o` and `slow_clk_o` follow `LEAD` edges after that. A request on `ratio_i` shows in the strobe spacing only from the period after the one in which it was sampled. The bench drives inputs and samples outputs on the falling edge. It steps a per-cycle reference model after each comparison, using the request the rising edge just saw. It keeps a history of the expected strobe so that `edge_o` and `slow_clk_o` are compared against the value from `LEAD` cycles earlier. Two instances, with leads of 1 and 3, see the same requests, so a single stream exercises both the legal switches and the held-off ones.

// File: rtl/cken_pkg.sv
package cken_pkg;

  // One pipeline tap: period-start marker and slow-clock level
  typedef struct packed {
    logic mark;
    logic hi;
  } cken_tap_t;

  // Smallest legal ratio for a given lead time
  function automatic int min_ratio(input int lead);
    return (lead > 1) ? 2 : 1;
  endfunction

endpackage

// File: rtl/cken_ratio_ctl.sv
module cken_ratio_ctl #(
  parameter int MAX_RATIO = 8,
  parameter int MIN_RATIO = 1,
  parameter int RATIO_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] req_i,
  input  logic               period_end_i,
  output logic [RATIO_W-1:0] cur_o
);

  localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] MAX_R = RATIO_W'(MAX_RATIO);

  logic legal;
  assign legal = (req_i >= MIN_R) && (req_i <= MAX_R);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o <= MIN_R;
    end else if (period_end_i && legal) begin
      cur_o <= req_i;
    end
  end

  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cur_o >= MIN_R) && (cur_o <= MAX_R)); // R5

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !period_end_i |=> $stable(cur_o)); // R4

endmodule

// File: rtl/cken_period_cnt.sv
module cken_period_cnt
  import cken_pkg::*;
#(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] cur_i,
  output logic               last_o,
  output cken_tap_t          tap_o
);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W:0]   half_up;

  assign half_up    = ({1'b0, cur_i} + 1'b1) >> 1;
  assign last_o     = (cnt_q == cur_i - 1'b1);
  assign tap_o.mark = (cnt_q == '0);
  assign tap_o.hi   = ({1'b0, cnt_q} < half_up);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (last_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (rst)
    cnt_q < cur_i); // R2

endmodule

// File: rtl/cken_lead_pipe.sv
module cken_lead_pipe
  import cken_pkg::*;
#(
  parameter int LEAD = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  cken_tap_t tap_i,
  output logic      en_o,
  output logic      edge_o,
  output logic      slow_o
);

  cken_tap_t stg_q [0:LEAD];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= LEAD; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= tap_i;
      for (int i = 1; i <= LEAD; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign en_o   = stg_q[0].mark;
  assign edge_o = stg_q[LEAD].mark;
  assign slow_o = stg_q[LEAD].hi;

endmodule

// File: rtl/cken_gen.sv
module cken_gen
  import cken_pkg::*;
#(
  parameter int MAX_RATIO = 8,
  parameter int LEAD      = 1,
  parameter int RATIO_W   = $clog2(MAX_RATIO + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               en_o,
  output logic               edge_o,
  output logic               slow_clk_o
);

  localparam int MIN_RATIO = min_ratio(LEAD);

  logic [RATIO_W-1:0] cur_ratio;
  logic               period_end;
  cken_tap_t          tap;

  cken_ratio_ctl #(
    .MAX_RATIO (MAX_RATIO),
    .MIN_RATIO (MIN_RATIO),
    .RATIO_W   (RATIO_W)
  ) u_ratio (
    .clk          (clk),
    .rst          (rst),
    .req_i        (ratio_i),
    .period_end_i (period_end),
    .cur_o        (cur_ratio)
  );

  cken_period_cnt #(
    .RATIO_W (RATIO_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .cur_i  (cur_ratio),
    .last_o (period_end),
    .tap_o  (tap)
  );

  cken_lead_pipe #(
    .LEAD (LEAD)
  ) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .tap_i  (tap),
    .en_o   (en_o),
    .edge_o (edge_o),
    .slow_o (slow_clk_o)
  );

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!en_o && !edge_o && !slow_clk_o)); // R1

  AST_EDGE_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
    edge_o |-> slow_clk_o); // R7

  generate
    if (LEAD == 1) begin : g_lead1_chk
      AST_LEAD_ONE: assert property (@(posedge clk) disable iff (rst)
        edge_o == $past(en_o)); // R3
    end
  endgenerate

endmodule

// File: tb/cken_gen_tb.sv
`timescale 1ns/1ps
module cken_gen_tb;

  localparam int MAXR = 8;
  localparam int RW   = 4;
  localparam int LD [2] = '{1, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] ratio_i = '0;
  logic [1:0] en_w, edge_w, slow_w;

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  bit done   = 1'b0;

  int m_cnt [2];
  int m_cur [2];
  bit h_en  [2][8];
  bit h_hi  [2][8];
  int last_en [2];
  int last_r  [2];
  int meas_iv [2];

  always #2 clk = ~clk;

  cken_gen #(.MAX_RATIO(MAXR), .LEAD(1)) u_dut (
    .clk(clk), .rst(rst), .ratio_i(ratio_i),
    .en_o(en_w[0]), .edge_o(edge_w[0]), .slow_clk_o(slow_w[0]));

  cken_gen #(.MAX_RATIO(MAXR), .LEAD(3)) u_dut_l3 (
    .clk(clk), .rst(rst), .ratio_i(ratio_i),
    .en_o(en_w[1]), .edge_o(edge_w[1]), .slow_clk_o(slow_w[1]));

  function automatic int minr(input int d);
    return (LD[d] > 1) ? 2 : 1;
  endfunction

  function automatic bit legal(input int d, input int r);
    return (r >= minr(d)) && (r <= MAXR);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      m_cnt[d] = 0; m_cur[d] = minr(d);
      for (int i = 0; i < 8; i++) begin h_en[d][i] = 0; h_hi[d][i] = 0; end
      last_en[d] = -1; last_r[d] = 0; meas_iv[d] = 0;
    end
  endtask

  // One fast cycle: called at the falling edge
  task automatic step();
    @(negedge clk);
    k++;
    for (int d = 0; d < 2; d++) begin
      for (int i = 7; i > 0; i--) begin h_en[d][i] = h_en[d][i-1]; h_hi[d][i] = h_hi[d][i-1]; end
      h_en[d][0] = (m_cnt[d] == 0);
      h_hi[d][0] = (m_cnt[d] < (m_cur[d] + 1) / 2);
      chk(en_w[d] == h_en[d][0], "R2 strobe", en_w[d], h_en[d][0]);
      chk(edge_w[d] == h_en[d][LD[d]], "R3 edge lead", edge_w[d], h_en[d][LD[d]]);
      chk(slow_w[d] == h_hi[d][LD[d]], "R7 slow level", slow_w[d], h_hi[d][LD[d]]);
      if (en_w[d]) begin
        if (last_en[d] >= 0) begin
          meas_iv[d] = k - last_en[d];
          chk(meas_iv[d] == last_r[d], "R4 period length", meas_iv[d], last_r[d]);
        end
        last_en[d] = k;
        last_r[d]  = m_cur[d];
      end
      if (m_cnt[d] == m_cur[d] - 1) begin
        m_cnt[d] = 0;
        if (legal(d, int'(ratio_i))) m_cur[d] = int'(ratio_i);
      end else begin
        m_cnt[d]++;
      end
    end
  endtask

  task automatic run(input int r, input int n);
    ratio_i = RW'(r);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset(input int r);
    @(negedge clk);
    rst = 1'b1;
    ratio_i = RW'(r);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      for (int d = 0; d < 2; d++)
        chk(!en_w[d] && !edge_w[d] && !slow_w[d], "R1 reset quiet",
            {en_w[d], edge_w[d], slow_w[d]}, 0);
    end
    model_reset();
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(1234));
    model_reset();
    do_reset(0);
    step();
    chk(en_w[0] && en_w[1], "R8 first strobe", en_w, 3);
    run(0, 20);
    chk(meas_iv[0] == 1, "R1 default ratio lead1", meas_iv[0], 1);
    chk(meas_iv[1] == 2, "R1 default ratio lead3", meas_iv[1], 2);
    chk(meas_iv[0] == 1, "R5 zero ignored", meas_iv[0], 1);
    run(3, 30);
    chk(meas_iv[0] == 3, "R2 ratio 3", meas_iv[0], 3);
    run(1, 20);
    chk(meas_iv[0] == 1, "R6 ratio 1 lead1", meas_iv[0], 1);
    chk(slow_w[0] && edge_w[0] && en_w[0], "R6 all high", {en_w[0], edge_w[0], slow_w[0]}, 7);
    chk(meas_iv[1] == 3, "R5 ratio 1 held off at lead3", meas_iv[1], 3);
    run(2, 20);
    run(0, 20);
    chk(meas_iv[0] == 2 && meas_iv[1] == 2, "R5 zero keeps 2", meas_iv[0], 2);
    run(8, 40);
    run(9, 40);
    chk(meas_iv[0] == 8 && meas_iv[1] == 8, "R5 above max ignored", meas_iv[0], 8);
    run(3, 1); run(1, 1); run(5, 30);
    // random phase with switches at arbitrary points
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 9) == 0) ratio_i = RW'($urandom_range(0, 15));
      step();
    end
    do_reset(7);
    step();
    chk(en_w[0] && en_w[1], "R8 strobe after second reset", en_w, 3);
    run(7, 60);
    chk(meas_iv[0] == 7, "R4 switch after reset", meas_iv[0], 7);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", k, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule